// File: doc/BRIEF.md
# Serial Receive Queue with Trigger Status

This block buffers bytes that a serial receiver has already deserialised, so that the CPU can collect them in bursts. It holds up to sixteen bytes in arrival order and reports how many are waiting. It raises a "threshold reached" flag (`rdf`) once the fill reaches a programmable level. It also raises a "leftover data" flag (`dr`) when a few bytes have been sitting below that level and the line has gone quiet for a while. Both flags drive a level receive interrupt and a one-cycle DMA request pulse, so either software or a DMA engine can drain the queue.

A byte that arrives while the queue is full is dropped, and the sticky overrun flag `orer` is set. Reception then stays blocked until software clears that flag. Status flags clear through write-zero-to-clear strobes. A zero write only takes effect when the condition behind the flag has gone away, so software cannot lose a pending event by clearing the flag too early. A queue reset input discards all stored bytes at once. The per-frame tick comes from the baud generator: one pulse for each frame time.

Top module: `rx_trig_fifo`

## Requirements
- R1: The queue stores up to 16 bytes and returns them in arrival order. `rx_count` gives the number of bytes stored (0 to 16) in the cycle after any push or pop.
- R2: `trig_sel` selects the threshold: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 14. After an accepted byte, if the new count is at or above the threshold, `rdf` is set and `dma_req` pulses for one cycle.
- R3: If a byte arrives while reception is allowed and the count is 16, that byte is discarded, the count stays at 16 and `orer` is set. `err_irq` is high while `orer` is set and either `rie` or `eie` is high.
- R4: A byte is accepted only while `rx_enable` is high and `orer` is low. Otherwise `rx_valid` has no effect on the count.
- R5: On a `frame_tick`, `dr` is set when three conditions hold. First, no byte arrived since the previous tick, counting a byte in the tick cycle itself. Second, no byte arrived in the interval before that. Third, the count is nonzero and below the threshold. When `dr` goes from clear to set, `dma_req` pulses.
- R6: A status write with `stat_keep_rdf` low clears `rdf` only if the count is below the threshold. CPU reads never clear `rdf`.
- R7: A status write with `stat_keep_dr` low clears `dr` only if the queue is empty.
- R8: `orer` is cleared only by `err_wr` with `err_keep` low. `err_wr` with `err_keep` high leaves it set.
- R9: `rx_irq` is high exactly when `rie` is high and at least one of `rdf` and `dr` is set.
- R10: `fifo_clr` empties the queue and clears `rdf` and `dr` by the next cycle, which deasserts `rx_irq`.
- R11: `rd_en` loads the oldest byte into `rd_data` in the next cycle and removes it. A read of an empty queue loads 0 and leaves the count at 0.
- R12: An accepted byte and a read in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is presented this cycle |
| rx_byte | input | 8 | Received byte |
| frame_tick | input | 1 | One pulse per serial frame time |
| rd_en | input | 1 | CPU read of the oldest byte |
| rx_enable | input | 1 | Receiver enable |
| rie | input | 1 | Receive interrupt enable |
| eie | input | 1 | Error interrupt enable |
| trig_sel | input | 2 | Threshold select (1, 4, 8, 14) |
| fifo_clr | input | 1 | Discard all stored bytes |
| stat_wr | input | 1 | Status write strobe |
| stat_keep_rdf | input | 1 | Written value for `rdf`; 0 requests a clear |
| stat_keep_dr | input | 1 | Written value for `dr`; 0 requests a clear |
| err_wr | input | 1 | Overrun register write strobe |
| err_keep | input | 1 | Written value for `orer`; 0 clears it |
| rd_data | output | 8 | Byte returned by the last read |
| rx_count | output | 5 | Number of stored bytes |
| rdf | output | 1 | Threshold reached flag |
| dr | output | 1 | Idle leftover data flag |
| orer | output | 1 | Overrun flag |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Error interrupt |
| dma_req | output | 1 | One-cycle DMA request pulse |

## Verification
The hardest state to reach is an idle-timeout `dr` with the count below the threshold. That state needs a threshold above the fill, bytes that arrive and then stop, and exactly three ticks with no further arrivals. The bench selects a threshold of 14, pushes two bytes and steps the ticks one at a time. This shows that the first two ticks leave `dr` clear and that the third sets it. The overrun path is reached by a full sixteen-byte fill at every threshold setting followed by one more byte. The same fill sweep checks that a read which frees a slot still leaves reception blocked until `orer` is written clear.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DEPTH = 16;
  localparam int RXQ_DW    = 8;
  localparam int RXQ_CW    = $clog2(RXQ_DEPTH + 1);

  // threshold table indexed by the 2-bit select
  function automatic logic [RXQ_CW-1:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_level = RXQ_CW'(1);
      2'd1:    trig_level = RXQ_CW'(4);
      2'd2:    trig_level = RXQ_CW'(8);
      default: trig_level = RXQ_CW'(14);
    endcase
  endfunction
endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int SLOTS = DEPTH + 1,
  localparam int PW    = $clog2(SLOTS),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          full,
  output logic          empty
);
  localparam logic [PW-1:0] LAST_PTR = PW'(SLOTS - 1);
  localparam logic [PW:0]   SLOTS_W  = (PW+1)'(SLOTS);

  logic [DW-1:0] mem [SLOTS];
  logic [PW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [PW:0]   diff;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    bump = (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    diff = {1'b0, wp_q} - {1'b0, rp_q};
    if (wp_q < rp_q) diff = diff + SLOTS_W;
    count     = diff[CW-1:0];
    full      = (count == CW'(DEPTH));
    empty     = (count == '0);
    count_nxt = count + CW'(push) - CW'(pop);
    head_data = mem[rp_q];
  end

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (clr) begin
      wp_d = '0;
      rp_d = '0;
    end else begin
      if (push) wp_d = bump(wp_q);
      if (pop)  rp_d = bump(rp_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  // storage has no reset; only written slots are ever read
  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp_q] <= wdata;
  end
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          arrive,
  input  logic          push,
  input  logic          overrun,
  input  logic          tick,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] count_nxt,
  input  logic [CW-1:0] trig,
  input  logic          stat_wr,
  input  logic          keep_rdf,
  input  logic          keep_dr,
  input  logic          err_wr,
  input  logic          err_keep,
  output logic          rdf,
  output logic          dr,
  output logic          orer,
  output logic          dma_req
);
  logic rdf_d, dr_d, orer_d, dma_d;
  logic since_q, since_d, last_q, last_d;
  logic rcvd, dr_set, rdf_hit;

  always_comb begin
    rcvd    = since_q | arrive;
    rdf_hit = push & (count_nxt >= trig);
    dr_set  = tick & ~rcvd & ~last_q & (count != '0) & (count < trig);

    since_d = tick ? 1'b0 : rcvd;
    last_d  = tick ? rcvd : last_q;

    rdf_d = rdf;
    if (stat_wr && !keep_rdf && (count < trig)) rdf_d = 1'b0;
    if (rdf_hit) rdf_d = 1'b1;

    dr_d = dr;
    if (stat_wr && !keep_dr && (count == '0)) dr_d = 1'b0;
    if (dr_set) dr_d = 1'b1;

    if (clr) begin
      rdf_d = 1'b0;
      dr_d  = 1'b0;
    end

    orer_d = orer;
    if (err_wr && !err_keep) orer_d = 1'b0;
    if (overrun) orer_d = 1'b1;

    dma_d = rdf_hit | (dr_set & ~dr & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdf     <= 1'b0;
      dr      <= 1'b0;
      orer    <= 1'b0;
      dma_req <= 1'b0;
      since_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      rdf     <= rdf_d;
      dr      <= dr_d;
      orer    <= orer_d;
      dma_req <= dma_d;
      since_q <= since_d;
      last_q  <= last_d;
    end
  end
endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = RXQ_DEPTH,
  parameter int DW    = RXQ_DW,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          frame_tick,
  input  logic          rd_en,
  input  logic          rx_enable,
  input  logic          rie,
  input  logic          eie,
  input  logic [1:0]    trig_sel,
  input  logic          fifo_clr,
  input  logic          stat_wr,
  input  logic          stat_keep_rdf,
  input  logic          stat_keep_dr,
  input  logic          err_wr,
  input  logic          err_keep,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] rx_count,
  output logic          rdf,
  output logic          dr,
  output logic          orer,
  output logic          rx_irq,
  output logic          err_irq,
  output logic          dma_req
);
  logic          allow, push, pop, overrun, full, empty;
  logic [CW-1:0] count_nxt, trig;
  logic [DW-1:0] head_data, rd_data_d;

  always_comb begin
    trig    = CW'(trig_level(trig_sel));
    allow   = rx_valid & rx_enable & ~orer;
    push    = allow & ~full & ~fifo_clr;
    overrun = allow & full;
    pop     = rd_en & ~empty & ~fifo_clr;
  end

  rxq_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fifo_clr),
    .push      (push),
    .pop       (pop),
    .wdata     (rx_byte),
    .head_data (head_data),
    .count     (rx_count),
    .count_nxt (count_nxt),
    .full      (full),
    .empty     (empty)
  );

  rxq_flags #(.CW(CW)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fifo_clr),
    .arrive    (allow),
    .push      (push),
    .overrun   (overrun),
    .tick      (frame_tick),
    .count     (rx_count),
    .count_nxt (count_nxt),
    .trig      (trig),
    .stat_wr   (stat_wr),
    .keep_rdf  (stat_keep_rdf),
    .keep_dr   (stat_keep_dr),
    .err_wr    (err_wr),
    .err_keep  (err_keep),
    .rdf       (rdf),
    .dr        (dr),
    .orer      (orer),
    .dma_req   (dma_req)
  );

  always_comb begin
    rd_data_d = rd_data;
    if (rd_en) rd_data_d = pop ? head_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_data_d;
  end

  always_comb begin
    rx_irq  = rie & (rdf | dr);
    err_irq = (rie | eie) & orer;
  end
endmodule

// File: rtl/rx_trig_fifo_chk.sv
module rx_trig_fifo_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_enable,
  input logic          rd_en,
  input logic          fifo_clr,
  input logic          err_wr,
  input logic          err_keep,
  input logic [CW-1:0] rx_count,
  input logic          rdf,
  input logic          dr,
  input logic          orer,
  input logic          dma_req
);
  // R1
  count_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(16));

  // R3
  orer_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(orer) |-> $past(rx_count == CW'(16) && rx_valid && rx_enable));

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == CW'(16) && !rd_en && !fifo_clr) |=> rx_count == CW'(16));

  // R8
  orer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (orer && !(err_wr && !err_keep)) |=> orer);

  // R10
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (rx_count == '0 && !rdf && !dr));

  // R2
  dma_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (rdf || dr));
endmodule

bind rx_trig_fifo rx_trig_fifo_chk #(.CW(CW)) u_chk (.*);

// File: tb/tb_rx_trig_fifo.sv
module tb_rx_trig_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 0, frame_tick = 0, rd_en = 0, rx_enable = 0;
  logic       rie = 0, eie = 0, fifo_clr = 0;
  logic       stat_wr = 0, stat_keep_rdf = 1, stat_keep_dr = 1, err_wr = 0, err_keep = 1;
  logic [7:0] rx_byte = '0;
  logic [1:0] trig_sel = '0;
  logic [7:0] rd_data;
  logic [4:0] rx_count;
  logic       rdf, dr, orer, rx_irq, err_irq, dma_req;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  rx_trig_fifo dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1; rx_byte = b; cyc(); rx_valid = 0;
  endtask

  task automatic rd();
    rd_en = 1; cyc(); rd_en = 0;
  endtask

  task automatic tick();
    frame_tick = 1; cyc(); frame_tick = 0;
  endtask

  task automatic stw(input logic krdf, input logic kdr);
    stat_wr = 1; stat_keep_rdf = krdf; stat_keep_dr = kdr; cyc();
    stat_wr = 0; stat_keep_rdf = 1; stat_keep_dr = 1;
  endtask

  task automatic erw(input logic k);
    err_wr = 1; err_keep = k; cyc(); err_wr = 0; err_keep = 1;
  endtask

  task automatic clr();
    fifo_clr = 1; cyc(); fifo_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    cyc();
    // reset state
    chk("R1 reset count", rx_count, 0);
    chk("R2 reset rdf", rdf, 0);
    chk("R5 reset dr", dr, 0);
    chk("R3 reset orer", orer, 0);
    chk("R11 reset rd_data", rd_data, 0);
    chk("R9 reset irq", rx_irq, 0);

    rx_enable = 1; rie = 1;
    for (int t = 0; t < 4; t++) begin
      int tl;
      tl = (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
      clr();
      trig_sel = 2'(t);
      for (int k = 1; k <= 16; k++) begin
        push(8'(t * 16 + k));
        chk("R1 count after push", rx_count, k);
        chk("R2 rdf vs threshold", rdf, int'(k >= tl));
        chk("R2 dma pulse", dma_req, int'(k >= tl));
        chk("R9 rx_irq follows rdf", rx_irq, int'(k >= tl));
      end
      push(8'hEE);
      chk("R3 overrun count", rx_count, 16);
      chk("R3 orer set", orer, 1);
      chk("R3 err_irq via rie", err_irq, 1);
      rd();
      chk("R11 first byte", rd_data, t * 16 + 1);
      chk("R1 count after read", rx_count, 15);
      push(8'h55);
      chk("R4 blocked by orer", rx_count, 15);
      stw(0, 1);
      chk("R6 rdf kept at/above threshold", rdf, 1);
      erw(1);
      chk("R8 keep write holds orer", orer, 1);
      erw(0);
      chk("R8 zero write clears orer", orer, 0);
      chk("R3 err_irq drops", err_irq, 0);
      for (int k = 2; k <= 16; k++) begin
        rd();
        chk("R1 fifo order", rd_data, t * 16 + k);
        chk("R1 count on drain", rx_count, 16 - k);
      end
      chk("R6 reads do not clear rdf", rdf, 1);
      stw(0, 1);
      chk("R6 rdf clears when below threshold", rdf, 0);
      chk("R9 rx_irq drops", rx_irq, 0);
      rd();
      chk("R11 empty read data", rd_data, 0);
      chk("R11 empty read count", rx_count, 0);
    end

    // R4: receiver disabled
    rx_enable = 0;
    push(8'h11);
    chk("R4 disabled push ignored", rx_count, 0);
    rx_enable = 1;

    // R5: idle timeout below threshold
    trig_sel = 2'd3;
    push(8'hA1); push(8'hA2);
    tick();
    chk("R5 no dr on arrival tick", dr, 0);
    tick();
    chk("R5 no dr one tick after", dr, 0);
    tick();
    chk("R5 dr after idle", dr, 1);
    chk("R5 dma on dr", dma_req, 1);
    chk("R9 rx_irq from dr", rx_irq, 1);
    stw(1, 0);
    chk("R7 dr kept while not empty", dr, 1);
    clr();
    chk("R10 clr count", rx_count, 0);
    chk("R10 clr dr", dr, 0);
    chk("R10 clr irq", rx_irq, 0);

    // R7: dr clears once empty
    push(8'hB1);
    tick(); tick(); tick();
    chk("R5 dr single byte", dr, 1);
    rd();
    chk("R7 read does not clear dr", dr, 1);
    stw(1, 0);
    chk("R7 dr cleared when empty", dr, 0);

    // R5: count at threshold gives no dr
    trig_sel = 2'd0;
    push(8'hC1);
    tick(); tick(); tick();
    chk("R5 no dr at threshold", dr, 0);
    chk("R2 rdf at threshold 1", rdf, 1);
    rie = 0;
    cyc();
    chk("R9 rx_irq masked", rx_irq, 0);
    rie = 1;
    clr();
    chk("R10 clr rdf", rdf, 0);

    // R12: simultaneous push and read
    push(8'hD1); push(8'hD2); push(8'hD3);
    rx_valid = 1; rx_byte = 8'hD4; rd_en = 1; cyc(); rx_valid = 0; rd_en = 0;
    chk("R12 count unchanged", rx_count, 3);
    chk("R12 read data", rd_data, 8'hD1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule